// File: doc/BRIEF.md
# DRAM Refresh Postponement Scheduler

This block decides when one DRAM rank should be refreshed. A free-running interval timer adds one to a count of owed refreshes each time the programmed refresh interval elapses. The scheduler lets that debt build up instead of refreshing at once. It raises a refresh request only when there is reason to: the rank has sat idle long enough (an opportunistic, low-priority refresh), the debt has reached a programmable high watermark, or it has reached a panic watermark. A separate watchdog on the time since the last refresh forces panic priority if it runs out.

The request and grant form a valid/ready pair toward the command arbiter. `ref_req` is valid, `ref_gnt` is ready, and a refresh is accepted in any cycle where both are high. A high or panic request holds until it is granted, and its priority can only rise while it waits. A low-priority request is an offer: it is withdrawn as soon as the rank stops being idle. After each accepted refresh, `blk_act` holds off activates for the refresh execution time, and no new request is shown during that window. A mode input can halve the refresh interval, either always or only when the DRAM reports warm or hot.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `ref_req` is 0, `ref_prio` is 00 and `blk_act` is 0.
- R2: The interval timer adds one owed refresh every P cycles, where P is the effective period. After k*P cycles with no accepted refresh, the owed count is k.
- R3: The effective period is `cfg_refi` halved (shifted right by one) when doubling is active, and `cfg_refi` otherwise. Doubling depends on `cfg_dbl_mode`: 00 doubles only while `dram_hot` is 1, 01 always doubles, 10 never doubles, and 11 acts like 00.
- R4: When the owed count is nonzero and at least `cfg_hi_wm`, the priority is high, encoded 10.
- R5: When the owed count is nonzero and at least `cfg_panic_wm`, the priority is panic, encoded 11. Panic outranks high.
- R6: When at least one refresh is owed and neither watermark is reached, a low-priority request (01) is raised if `rank_idle` has been 1 for at least `cfg_idle_thr` consecutive cycles. Otherwise the priority is 00.
- R7: A refresh is accepted on a clock edge where `ref_req` and `ref_gnt` are both 1, and this removes one owed refresh (not below zero). If an interval expiry and an acceptance fall on the same edge, the owed count is unchanged.
- R8: After an accepted refresh, `blk_act` is 1 for exactly `cfg_rfc` cycles. While `blk_act` is 1, `ref_req` is 0 and the priority is 00.
- R9: The owed count saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R10: Once `cfg_limit`*1024 cycles have passed since reset or the last accepted refresh, the priority is forced to panic (11) whatever the owed count. An accepted refresh restarts that count. A `cfg_limit` of 0 turns this limit off.
- R11: `ref_req` is 1 exactly when `ref_prio` is not 00. A high or panic request stays asserted, with priority bit 1 set, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_refi | input | 16 | Programmed refresh interval in cycles |
| cfg_rfc | input | 9 | Refresh execution time in cycles |
| cfg_idle_thr | input | 8 | Idle cycles needed for an opportunistic refresh |
| cfg_hi_wm | input | 4 | Owed count that makes the request high priority |
| cfg_panic_wm | input | 4 | Owed count that makes the request panic priority |
| cfg_limit | input | 7 | No-refresh limit in units of 1024 cycles, 0 = off |
| cfg_dbl_mode | input | 2 | Rate-doubling mode |
| dram_hot | input | 1 | DRAM is warm or hot |
| rank_idle | input | 1 | Rank has no pending traffic |
| ref_gnt | input | 1 | Arbiter accepts the refresh (ready) |
| ref_req | output | 1 | Refresh request (valid) |
| ref_prio | output | 2 | Request priority: 00 none, 01 low, 10 high, 11 panic |
| blk_act | output | 1 | Activates and refreshes are held off |

## Verification
The interval timer's expiry and the arbiter's grant can land on the same clock edge. One of them adds an owed refresh and the other removes one. The bench lines up a grant with the edge on which the timer rolls over. The watermarks are set so that the three possible outcomes give three different priorities: a lost increment gives none, a lost decrement gives panic, and the correct unchanged count gives high.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    PRIO_NONE  = 2'b00,
    PRIO_LOW   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_PANIC = 2'b11
  } ref_prio_e;

  typedef enum logic [1:0] {
    DBL_THERMAL = 2'b00,
    DBL_ALWAYS  = 2'b01,
    DBL_NEVER   = 2'b10,
    DBL_RSVD    = 2'b11
  } dbl_mode_e;

  // Reserved encoding falls back to the thermal rule.
  function automatic logic dbl_active(input logic [1:0] mode, input logic hot);
    case (dbl_mode_e'(mode))
      DBL_ALWAYS: return 1'b1;
      DBL_NEVER:  return 1'b0;
      default:    return hot;
    endcase
  endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic                halve,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] eff;
  logic [PERIOD_W-1:0] last;

  always_comb begin
    eff  = halve ? {1'b0, period[PERIOD_W-1:1]} : period;
    last = (eff == '0) ? '0 : eff - 1'b1;
    tick = (cnt_q >= last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owed_counter.sv
module owed_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic             take,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({add, take})
        2'b10:   if (count != CNT_MAX) count <= count + 1'b1;
        2'b01:   if (count != '0)      count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sat_up_counter.sv
module sat_up_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       count <= '0;
    else if (count != TOP)   count <= count + 1'b1;
  end
endmodule

// File: rtl/hold_window.sv
module hold_window #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               left_q <= '0;
    else if (load)            left_q <= len;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int PERIOD_W  = 16,
  parameter int RFC_W     = 9,
  parameter int IDLE_W    = 8,
  parameter int CNT_W     = 4,
  parameter int LIM_W     = 7,
  parameter int LIM_SHIFT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] cfg_refi,
  input  logic [RFC_W-1:0]    cfg_rfc,
  input  logic [IDLE_W-1:0]   cfg_idle_thr,
  input  logic [CNT_W-1:0]    cfg_hi_wm,
  input  logic [CNT_W-1:0]    cfg_panic_wm,
  input  logic [LIM_W-1:0]    cfg_limit,
  input  logic [1:0]          cfg_dbl_mode,
  input  logic                dram_hot,
  input  logic                rank_idle,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic [1:0]          ref_prio,
  output logic                blk_act
);
  localparam int LIMC_W = LIM_W + LIM_SHIFT;

  logic              tick;
  logic              accept;
  logic              dbl_on;
  logic [CNT_W-1:0]  owed_q;
  logic [IDLE_W-1:0] idle_cnt;
  logic [LIMC_W-1:0] lim_cnt;
  logic [LIMC_W-1:0] lim_cycles;
  logic              lim_hit;
  logic              owed_nz;
  logic              opp;
  ref_prio_e         prio;

  assign dbl_on = dbl_active(cfg_dbl_mode, dram_hot);

  refi_timer #(.PERIOD_W(PERIOD_W)) u_refi (
    .clk(clk), .rst_n(rst_n), .period(cfg_refi), .halve(dbl_on), .tick(tick)
  );

  owed_counter #(.CNT_W(CNT_W)) u_owed (
    .clk(clk), .rst_n(rst_n), .add(tick), .take(accept), .count(owed_q)
  );

  sat_up_counter #(.W(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(!rank_idle), .count(idle_cnt)
  );

  sat_up_counter #(.W(LIMC_W)) u_limit (
    .clk(clk), .rst_n(rst_n), .clr(accept), .count(lim_cnt)
  );

  hold_window #(.W(RFC_W)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(cfg_rfc), .busy(blk_act)
  );

  assign lim_cycles = {cfg_limit, {LIM_SHIFT{1'b0}}};
  assign lim_hit    = (cfg_limit != '0) && (lim_cnt >= lim_cycles);
  assign owed_nz    = (owed_q != '0);
  assign opp        = rank_idle && (idle_cnt >= cfg_idle_thr);

  always_comb begin
    if (blk_act)                                          prio = PRIO_NONE;
    else if (lim_hit || (owed_nz && owed_q >= cfg_panic_wm)) prio = PRIO_PANIC;
    else if (owed_nz && owed_q >= cfg_hi_wm)              prio = PRIO_HIGH;
    else if (owed_nz && opp)                              prio = PRIO_LOW;
    else                                                  prio = PRIO_NONE;
  end

  assign ref_prio = prio;
  assign ref_req  = (prio != PRIO_NONE);
  assign accept   = ref_req && ref_gnt;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int CNT_W = 4,
  parameter int RFC_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic [1:0]       ref_prio,
  input logic             ref_gnt,
  input logic             blk_act,
  input logic             rank_idle,
  input logic [RFC_W-1:0] cfg_rfc,
  input logic [CNT_W-1:0] owed,
  input logic             accept
);
  localparam logic [CNT_W-1:0] OWED_TOP = '1;

  assert_no_req_in_rfc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_act |-> !ref_req);

  assert_block_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && cfg_rfc != '0) |=> blk_act);

  assert_low_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_prio == 2'b01) |-> rank_idle);

  assert_owed_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == OWED_TOP && !accept) |=> owed == OWED_TOP);

  assert_urgent_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_prio[1] && !ref_gnt) |=> (ref_req && ref_prio[1]));
endmodule

bind refresh_sched refresh_sched_chk #(.CNT_W(CNT_W), .RFC_W(RFC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_prio(ref_prio),
  .ref_gnt(ref_gnt), .blk_act(blk_act), .rank_idle(rank_idle),
  .cfg_rfc(cfg_rfc), .owed(owed_q), .accept(accept)
);

// File: tb/test_refresh_sched.sv
`timescale 1ns/1ps
module test_refresh_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_refi = 16'd10;
  logic [8:0]  cfg_rfc = '0;
  logic [7:0]  cfg_idle_thr = 8'd255;
  logic [3:0]  cfg_hi_wm = 4'd15;
  logic [3:0]  cfg_panic_wm = 4'd15;
  logic [6:0]  cfg_limit = '0;
  logic [1:0]  cfg_dbl_mode = 2'b10;
  logic        dram_hot = 1'b0;
  logic        rank_idle = 1'b0;
  logic        ref_gnt = 1'b0;
  logic        ref_req;
  logic [1:0]  ref_prio;
  logic        blk_act;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  refresh_sched i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi), .cfg_rfc(cfg_rfc),
    .cfg_idle_thr(cfg_idle_thr), .cfg_hi_wm(cfg_hi_wm), .cfg_panic_wm(cfg_panic_wm),
    .cfg_limit(cfg_limit), .cfg_dbl_mode(cfg_dbl_mode), .dram_hot(dram_hot),
    .rank_idle(rank_idle), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_prio(ref_prio), .blk_act(blk_act)
  );

  typedef struct packed {
    logic [15:0] refi;
    logic [1:0]  mode;
    logic        hot;
    logic [3:0]  hi;
    logic [3:0]  pn;
    logic [7:0]  thr;
    logic        idle;
    logic [15:0] edges;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'd10, 2'd2, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd19, 2'd0}, // R2 owed 1
    '{16'd10, 2'd2, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd20, 2'd2}, // R4 owed 2
    '{16'd10, 2'd2, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd30, 2'd3}, // R5 owed 3
    '{16'd20, 2'd1, 1'b0, 4'd2, 4'd3, 8'd5, 1'b0, 16'd19, 2'd0}, // R3 always, owed 1
    '{16'd20, 2'd1, 1'b0, 4'd2, 4'd3, 8'd5, 1'b0, 16'd20, 2'd2}, // R3 always, owed 2
    '{16'd20, 2'd0, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd30, 2'd3}, // R3 thermal hot
    '{16'd20, 2'd0, 1'b0, 4'd2, 4'd3, 8'd5, 1'b0, 16'd30, 2'd0}, // R3 thermal cool
    '{16'd20, 2'd3, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd20, 2'd2}, // R3 reserved as thermal
    '{16'd20, 2'd0, 1'b0, 4'd2, 4'd3, 8'd5, 1'b1, 16'd30, 2'd1}, // R6 idle low
    '{16'd3,  2'd2, 1'b0, 4'd15, 4'd15, 8'd5, 1'b1, 16'd4, 2'd0}, // R6 idle 4 < 5
    '{16'd3,  2'd2, 1'b0, 4'd15, 4'd15, 8'd5, 1'b1, 16'd5, 2'd1}, // R6 idle 5 = 5
    '{16'd20, 2'd2, 1'b1, 4'd2, 4'd3, 8'd5, 1'b0, 16'd30, 2'd0}  // R3 never, hot ignored
  };

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    run(3);
    rst_n = 1'b1;
  endtask

  task automatic grant_once();
    ref_gnt = 1'b1;
    run(1);
    ref_gnt = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: during and right after reset
    run(2);
    chk(ref_req, 0, "R1 req in reset");
    chk(ref_prio, 0, "R1 prio in reset");
    chk(blk_act, 0, "R1 block in reset");
    restart();
    chk(ref_req, 0, "R1 req after release");
    chk(ref_prio, 0, "R1 prio after release");
    chk(blk_act, 0, "R1 block after release");

    // Table walk: R2/R3/R4/R5/R6, each also checks R11 request encoding
    for (int i = 0; i < NV; i++) begin
      cfg_refi = VECS[i].refi; cfg_dbl_mode = VECS[i].mode; dram_hot = VECS[i].hot;
      cfg_hi_wm = VECS[i].hi; cfg_panic_wm = VECS[i].pn; cfg_idle_thr = VECS[i].thr;
      rank_idle = VECS[i].idle; cfg_rfc = '0; cfg_limit = '0;
      restart();
      run(int'(VECS[i].edges));
      chk(ref_prio, VECS[i].exp, $sformatf("R2/R3/R4/R5/R6 vector %0d prio", i));
      chk(ref_req, (VECS[i].exp != 2'd0), $sformatf("R11 vector %0d req", i));
    end

    // R8 / R7 / R11: hold, grant, refresh window
    cfg_refi = 16'd10; cfg_dbl_mode = 2'b10; dram_hot = 1'b0; cfg_hi_wm = 4'd1;
    cfg_panic_wm = 4'd2; cfg_idle_thr = 8'd255; rank_idle = 1'b0; cfg_rfc = 9'd5;
    cfg_limit = '0;
    restart();
    run(20);
    chk(ref_prio, 3, "R5 panic at owed 2");
    run(3);
    chk(ref_req, 1, "R11 panic request held");
    chk(ref_prio, 3, "R11 panic priority held");
    grant_once();
    chk(blk_act, 1, "R8 block right after grant");
    chk(ref_req, 0, "R8 no request in window");
    for (int k = 0; k < 4; k++) begin
      run(1);
      chk(blk_act, 1, $sformatf("R8 block cycle %0d", k + 2));
    end
    run(1);
    chk(blk_act, 0, "R8 block ends after rfc cycles");
    chk(ref_prio, 2, "R7 owed dropped to 1 gives high");

    // R7: interval expiry and grant on the same edge
    cfg_rfc = '0;
    restart();
    run(19);
    chk(ref_prio, 2, "R7 high before coincident edge");
    grant_once();
    chk(ref_prio, 2, "R7 tick and grant together keep count");

    // R9: saturation
    cfg_refi = 16'd4; cfg_hi_wm = 4'd14; cfg_panic_wm = 4'd15;
    restart();
    run(100);
    chk(ref_prio, 3, "R9 saturated count at panic");
    cfg_refi = 16'hFFFF;
    grant_once();
    chk(ref_prio, 2, "R9 count 14 after one grant");
    grant_once();
    chk(ref_prio, 0, "R9 count 13 after two grants");

    // R10: no-refresh limit
    cfg_refi = 16'hFFFF; cfg_hi_wm = 4'd15; cfg_panic_wm = 4'd15; cfg_limit = 7'd1;
    restart();
    run(1023);
    chk(ref_prio, 0, "R10 before limit");
    run(1);
    chk(ref_prio, 3, "R10 limit forces panic");
    grant_once();
    chk(ref_prio, 0, "R10 limit restarts on grant");
    cfg_limit = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule